// File: doc/BRIEF.md
# DMA Channel Completion Collector

This block gathers end-of-transfer results from a bank of DMA channels that serve one execution environment, and lets software collect them through a small word-addressed register window. Each channel has its own short queue of result words. The channel engine reports a finished transfer with a one-cycle strobe and an error flag. Software can also abort a channel by writing to its flush register. The abort then leaves its own result word in the queue, if that channel allows flushed results to be reported.

Software reads a per-channel status word or a shared summary word to find out which channels hold results. A read of a channel's result register hands back the oldest word and removes it from the queue. The interrupt output is a level. It stays high as long as any channel whose interrupt is enabled still holds a result. Moving the data itself is done elsewhere. This block only sees the completion strobes and drives one abort strobe per channel.

Top module: `dma_result_collector`

## Requirements
- R1: After synchronous reset every queue is empty, every enable bit is clear, and `irq`, `chan_abort` and the summary word read as zero.
- R2: An engine strobe on `post_valid[i]` queues the word 0x80000002 when `post_err[i]` is low and 0x8000000A when it is high. Bit 31 means valid, bit 3 error, bit 2 flushed and bit 1 completed normally.
- R3: A read of address 0x040+4*i returns the oldest word of channel i in `reg_rdata` on the cycle after the read and removes that word. If the queue is empty the read returns 0 and changes nothing.
- R4: Address 0x200+4*i reads 0x2 (bit 1 set) while channel i holds at least one result, and 0 otherwise. Address 0x380 reads a word whose bit i is set while channel i holds a result.
- R5: Address 0x300+4*i is a read/write configuration word. Bit 0 enables the interrupt of channel i and bit 1 enables reporting of flushed results. The other bits read as zero.
- R6: A write of any data to address 0x080+4*i raises `chan_abort[i]` for exactly the next cycle. When bit 1 of that channel's configuration is set, the write also queues 0x80000004. An engine strobe on the same channel in the same cycle is dropped.
- R7: Each queue holds up to 4 words and hands them out in arrival order. A new word that arrives at a full queue in a cycle with no pop replaces the newest entry, with bit 3 (error) forced on. A pop and a push in the same cycle on a full queue lose nothing.
- R8: `irq` is high exactly when at least one channel with its interrupt enabled holds a result.
- R9: Reads of any other address, including the command pointer bank at 0x000, return 0. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| post_valid | input | 16 | Per-channel end-of-transfer strobe from the channel engines |
| post_err | input | 16 | Per-channel error flag, qualified by post_valid |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, updated on the clock edge that takes a read |
| irq | output | 1 | Level interrupt |
| chan_abort | output | 16 | One-cycle abort strobe per channel toward the engines |

## Verification
Every input change is timed against one rising edge. Queue contents, status, summary and the `irq` level all change at that edge. Read data comes from a register loaded at the same edge from the state before it, so a popped word shows up one cycle after the read. The abort strobe is high only during the cycle that follows the flush write. The bench drives on falling edges and compares on the next falling edge against a model it updates in the same order: it takes the read value from the old state, then pops, then pushes. So every check samples exactly the cycle in which its result is due.

// File: rtl/rc_pkg.sv
package rc_pkg;

    localparam int RC_AW = 12;
    localparam int RC_DW = 32;

    // Result word bit positions (software decodes these)
    localparam int RES_VALID_BIT = 31;
    localparam int RES_ERR_BIT   = 3;
    localparam int RES_FLUSH_BIT = 2;
    localparam int RES_DONE_BIT  = 1;
    localparam int STAT_AVAIL_BIT = 1;
    localparam int CONF_IEN_BIT   = 0;
    localparam int CONF_FEN_BIT   = 1;

    // Bank base addresses, 4 bytes per channel
    localparam logic [RC_AW-1:0] BASE_CMDPTR  = 12'h000;
    localparam logic [RC_AW-1:0] BASE_RESULT  = 12'h040;
    localparam logic [RC_AW-1:0] BASE_FLUSH   = 12'h080;
    localparam logic [RC_AW-1:0] BASE_STATUS  = 12'h200;
    localparam logic [RC_AW-1:0] BASE_CONF    = 12'h300;
    localparam logic [RC_AW-1:0] ADDR_SUMMARY = 12'h380;

    typedef struct packed {
        logic valid;
        logic err;
        logic flushed;
        logic done;
    } rc_result_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CMDPTR,
        SEL_RESULT,
        SEL_FLUSH,
        SEL_STATUS,
        SEL_CONF,
        SEL_SUMMARY
    } rc_sel_e;

    function automatic logic [RC_DW-1:0] rc_pack(input rc_result_t r);
        logic [RC_DW-1:0] w;
        w = '0;
        w[RES_VALID_BIT] = r.valid;
        w[RES_ERR_BIT]   = r.err;
        w[RES_FLUSH_BIT] = r.flushed;
        w[RES_DONE_BIT]  = r.done;
        return w;
    endfunction

    function automatic rc_result_t rc_engine_result(input logic err);
        rc_result_t r;
        r.valid   = 1'b1;
        r.err     = err;
        r.flushed = 1'b0;
        r.done    = 1'b1;
        return r;
    endfunction

    function automatic rc_result_t rc_flush_result();
        rc_result_t r;
        r.valid   = 1'b1;
        r.err     = 1'b0;
        r.flushed = 1'b1;
        r.done    = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/rc_addr_decode.sv
module rc_addr_decode
    import rc_pkg::*;
#(
    parameter int NCH = 16,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [RC_AW-1:0] addr,
    output rc_sel_e          sel,
    output logic [CW-1:0]    ch
);

    localparam logic [RC_AW-1:0] BANK_BYTES = RC_AW'(4 * NCH);

    function automatic logic in_bank(input logic [RC_AW-1:0] a,
                                     input logic [RC_AW-1:0] base);
        return (a >= base) && (a < base + BANK_BYTES);
    endfunction

    always_comb begin
        sel = SEL_NONE;
        ch  = '0;
        if (addr == ADDR_SUMMARY) begin
            sel = SEL_SUMMARY;
        end else if (in_bank(addr, BASE_CMDPTR)) begin
            sel = SEL_CMDPTR;
            ch  = CW'((addr - BASE_CMDPTR) >> 2);
        end else if (in_bank(addr, BASE_RESULT)) begin
            sel = SEL_RESULT;
            ch  = CW'((addr - BASE_RESULT) >> 2);
        end else if (in_bank(addr, BASE_FLUSH)) begin
            sel = SEL_FLUSH;
            ch  = CW'((addr - BASE_FLUSH) >> 2);
        end else if (in_bank(addr, BASE_STATUS)) begin
            sel = SEL_STATUS;
            ch  = CW'((addr - BASE_STATUS) >> 2);
        end else if (in_bank(addr, BASE_CONF)) begin
            sel = SEL_CONF;
            ch  = CW'((addr - BASE_CONF) >> 2);
        end
    end

endmodule

// File: rtl/rc_result_queue.sv
module rc_result_queue
    import rc_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW   = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  rc_result_t push_res,
    input  logic       pop,
    output rc_result_t head,
    output logic       nonempty
);

    rc_result_t        mem [DEPTH];
    logic [PW-1:0]     rd_ptr;
    logic [PW-1:0]     wr_ptr;
    logic [CNTW-1:0]   cnt;

    logic full;
    logic do_pop;
    logic do_append;
    logic do_clobber;
    rc_result_t marked;

    assign full       = (cnt == CNTW'(DEPTH));
    assign do_pop     = pop && (cnt != '0);
    assign do_append  = push && (!full || do_pop);
    assign do_clobber = push && full && !do_pop;

    always_comb begin
        marked     = push_res;
        marked.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_pop)
                rd_ptr <= rd_ptr + PW'(1);
            if (do_append)
                wr_ptr <= wr_ptr + PW'(1);
            if (do_append && !do_pop)
                cnt <= cnt + CNTW'(1);
            else if (do_pop && !do_append)
                cnt <= cnt - CNTW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_append)
            mem[wr_ptr] <= push_res;
        else if (do_clobber)
            mem[wr_ptr - PW'(1)] <= marked;
    end

    assign head     = mem[rd_ptr];
    assign nonempty = (cnt != '0);

endmodule

// File: rtl/dma_result_collector.sv
module dma_result_collector
    import rc_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int DEPTH = 4,
    localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   post_valid,
    input  logic [NCH-1:0]   post_err,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [RC_AW-1:0] reg_addr,
    input  logic [RC_DW-1:0] reg_wdata,
    output logic [RC_DW-1:0] reg_rdata,
    output logic             irq,
    output logic [NCH-1:0]   chan_abort
);

    rc_sel_e        sel;
    logic [CW-1:0]  sel_ch;
    logic [NCH-1:0] ch_onehot;
    logic [NCH-1:0] flush_hit;
    logic [NCH-1:0] pop_hit;
    logic [NCH-1:0] pend;
    logic [NCH-1:0] ien_q;
    logic [NCH-1:0] fen_q;
    rc_result_t     head_q [NCH];
    logic [RC_DW-1:0] rd_word;
    logic           unused_wdata;

    assign unused_wdata = ^reg_wdata[RC_DW-1:2];

    rc_addr_decode #(.NCH(NCH)) u_dec (
        .addr (reg_addr),
        .sel  (sel),
        .ch   (sel_ch)
    );

    assign ch_onehot = NCH'(1) << sel_ch;
    assign flush_hit = (reg_wr && sel == SEL_FLUSH)  ? ch_onehot : '0;
    assign pop_hit   = (reg_rd && sel == SEL_RESULT) ? ch_onehot : '0;

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_chan
            logic       push_i;
            rc_result_t res_i;

            assign push_i = flush_hit[gi] ? fen_q[gi] : post_valid[gi];
            assign res_i  = flush_hit[gi] ? rc_flush_result()
                                          : rc_engine_result(post_err[gi]);

            rc_result_queue #(.DEPTH(DEPTH)) u_q (
                .clk      (clk),
                .rst      (rst),
                .push     (push_i),
                .push_res (res_i),
                .pop      (pop_hit[gi]),
                .head     (head_q[gi]),
                .nonempty (pend[gi])
            );
        end
    endgenerate

    // Per-channel configuration bits
    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q <= '0;
            fen_q <= '0;
        end else if (reg_wr && sel == SEL_CONF) begin
            ien_q[sel_ch] <= reg_wdata[CONF_IEN_BIT];
            fen_q[sel_ch] <= reg_wdata[CONF_FEN_BIT];
        end
    end

    // Abort strobe toward the engines
    always_ff @(posedge clk) begin
        if (rst)
            chan_abort <= '0;
        else
            chan_abort <= flush_hit;
    end

    // Read mux
    always_comb begin
        rd_word = '0;
        unique case (sel)
            SEL_RESULT:  rd_word = pend[sel_ch] ? rc_pack(head_q[sel_ch]) : '0;
            SEL_STATUS:  rd_word[STAT_AVAIL_BIT] = pend[sel_ch];
            SEL_CONF: begin
                rd_word[CONF_IEN_BIT] = ien_q[sel_ch];
                rd_word[CONF_FEN_BIT] = fen_q[sel_ch];
            end
            SEL_SUMMARY: rd_word = RC_DW'(pend);
            default:     rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= rd_word;
    end

    assign irq = |(pend & ien_q);

endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
    parameter int NCH = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           reg_wr,
    input logic           reg_rd,
    input logic [11:0]    reg_addr,
    input logic [31:0]    reg_rdata,
    input logic [NCH-1:0] post_valid,
    input logic           irq,
    input logic [NCH-1:0] chan_abort,
    input logic [NCH-1:0] pend
);

    logic rd_result;
    logic rd_hit_pend;
    assign rd_result   = reg_rd && (reg_addr[11:6] == 6'h01);
    assign rd_hit_pend = ((pend >> reg_addr[5:2]) & NCH'(1)) != '0;

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pend == '0 && !irq && chan_abort == '0));

    assert_empty_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_result && !rd_hit_pend) |=> (reg_rdata == 32'h0));

    assert_pending_read_valid_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_result && rd_hit_pend) |=> reg_rdata[31]);

    assert_summary_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (post_valid == '0 && !reg_wr && !reg_rd) |=> $stable(pend));

    assert_abort_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chan_abort));

    assert_abort_follows_flush_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr[11:6] == 6'h02) |=> (chan_abort != '0));

    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past((post_valid != '0) || reg_wr));

endmodule

bind dma_result_collector rc_checker #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .post_valid (post_valid),
    .irq        (irq),
    .chan_abort (chan_abort),
    .pend       (pend)
);

// File: tb/dma_result_collector_test.sv
module dma_result_collector_test;

    localparam int NCH   = 16;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst;
    logic [NCH-1:0] post_valid;
    logic [NCH-1:0] post_err;
    logic           reg_wr;
    logic           reg_rd;
    logic [11:0]    reg_addr;
    logic [31:0]    reg_wdata;
    logic [31:0]    reg_rdata;
    logic           irq;
    logic [NCH-1:0] chan_abort;

    dma_result_collector #(.NCH(NCH), .DEPTH(DEPTH)) uut (
        .clk        (clk),
        .rst        (rst),
        .post_valid (post_valid),
        .post_err   (post_err),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq        (irq),
        .chan_abort (chan_abort)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference model
    logic [31:0] mq [NCH][DEPTH];
    int          mcnt [NCH];
    logic        mien [NCH];
    logic        mfen [NCH];

    function automatic logic [11:0] addr_of(input logic [11:0] base, input int ch);
        return base + 12'(ch * 4);
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        int ch;
        logic [31:0] w;
        ch = int'(a[5:2]);
        w = 32'h0;
        if (a == 12'h380) begin
            for (int i = 0; i < NCH; i++) w[i] = (mcnt[i] > 0);
        end else if (a[11:6] == 6'h01) begin
            w = (mcnt[ch] > 0) ? mq[ch][0] : 32'h0;
        end else if (a[11:6] == 6'h08) begin
            w = (mcnt[ch] > 0) ? 32'h2 : 32'h0;
        end else if (a[11:6] == 6'h0C) begin
            w = {30'b0, mfen[ch], mien[ch]};
        end
        return w;
    endfunction

    function automatic void model_push(input int ch, input logic [31:0] w);
        if (mcnt[ch] < DEPTH) begin
            mq[ch][mcnt[ch]] = w;
            mcnt[ch]++;
        end else begin
            mq[ch][DEPTH-1] = w | 32'h8;
        end
    endfunction

    function automatic void model_step(input logic [NCH-1:0] pv, input logic [NCH-1:0] pe,
                                       input logic wr, input logic rd,
                                       input logic [11:0] a, input logic [31:0] wd);
        int ch;
        ch = int'(a[5:2]);
        if (rd && a[11:6] == 6'h01 && mcnt[ch] > 0) begin
            for (int k = 0; k < DEPTH - 1; k++) mq[ch][k] = mq[ch][k+1];
            mcnt[ch]--;
        end
        for (int i = 0; i < NCH; i++) begin
            if (wr && a[11:6] == 6'h02 && ch == i) begin
                if (mfen[i]) model_push(i, 32'h80000004);
            end else if (pv[i]) begin
                model_push(i, pe[i] ? 32'h8000000A : 32'h80000002);
            end
        end
        if (wr && a[11:6] == 6'h0C) begin
            mien[ch] = wd[0];
            mfen[ch] = wd[1];
        end
    endfunction

    function automatic logic model_irq();
        logic r;
        r = 1'b0;
        for (int i = 0; i < NCH; i++) if (mien[i] && mcnt[i] > 0) r = 1'b1;
        return r;
    endfunction

    function automatic string auto_tag(input logic [11:0] a);
        if (a[11:6] == 6'h01) return "R3";
        if (a[11:6] == 6'h08 || a == 12'h380) return "R4";
        if (a[11:6] == 6'h0C) return "R5";
        return "R9";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cycle(input logic [NCH-1:0] pv, input logic [NCH-1:0] pe,
                         input logic wr, input logic rd,
                         input logic [11:0] a, input logic [31:0] wd,
                         input string tag);
        logic [31:0]    er;
        logic [NCH-1:0] ea;
        string          t;
        post_valid = pv;
        post_err   = pe;
        reg_wr     = wr;
        reg_rd     = rd;
        reg_addr   = a;
        reg_wdata  = wd;
        er = model_read(a);
        ea = (wr && a[11:6] == 6'h02) ? (NCH'(1) << a[5:2]) : '0;
        model_step(pv, pe, wr, rd, a, wd);
        @(negedge clk);
        t = (tag == "") ? auto_tag(a) : tag;
        if (rd) check(t, reg_rdata, er);
        check("R8", {31'b0, irq}, {31'b0, model_irq()});
        check("R6", 32'(chan_abort), 32'(ea));
    endtask

    task automatic rd_reg(input logic [11:0] a, input string tag);
        cycle('0, '0, 1'b0, 1'b1, a, 32'h0, tag);
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        cycle('0, '0, 1'b1, 1'b0, a, d, "");
    endtask

    task automatic post(input int ch, input logic err);
        cycle(NCH'(1) << ch, err ? (NCH'(1) << ch) : '0, 1'b0, 1'b0, 12'h3FC, 32'h0, "");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NCH; i++) begin
            mcnt[i] = 0; mien[i] = 1'b0; mfen[i] = 1'b0;
        end
        rst = 1'b1;
        post_valid = '0; post_err = '0;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1", {31'b0, irq}, 32'h0);
        check("R1", 32'(chan_abort), 32'h0);
        rd_reg(12'h380, "R1");
        rd_reg(addr_of(12'h300, 0), "R1");

        // R5: configuration read-back
        wr_reg(addr_of(12'h300, 3), 32'hFFFF_FFFF);
        rd_reg(addr_of(12'h300, 3), "R5");

        // R2: normal completion and error completion
        post(3, 1'b0);
        rd_reg(addr_of(12'h200, 3), "R4");
        rd_reg(addr_of(12'h040, 3), "R2");
        rd_reg(addr_of(12'h040, 3), "R3");
        post(3, 1'b1);
        rd_reg(addr_of(12'h040, 3), "R2");

        // R6: flush with reporting enabled and disabled
        wr_reg(addr_of(12'h080, 3), 32'h0);
        rd_reg(addr_of(12'h040, 3), "R6");
        wr_reg(addr_of(12'h080, 5), 32'h1234);
        rd_reg(addr_of(12'h200, 5), "R6");
        cycle(NCH'(1) << 3, '0, 1'b1, 1'b0, addr_of(12'h080, 3), 32'h0, "");
        rd_reg(12'h380, "R6");
        rd_reg(addr_of(12'h040, 3), "R6");
        rd_reg(addr_of(12'h200, 3), "R6");

        // R7: overflow on a channel with interrupts disabled
        for (int k = 0; k < 5; k++) post(7, 1'b0);
        rd_reg(addr_of(12'h200, 7), "R7");
        for (int k = 0; k < 5; k++) rd_reg(addr_of(12'h040, 7), "R7");
        for (int k = 0; k < 4; k++) post(7, k == 3);
        cycle(NCH'(1) << 7, '0, 1'b0, 1'b1, addr_of(12'h040, 7), 32'h0, "R7");
        for (int k = 0; k < 4; k++) rd_reg(addr_of(12'h040, 7), "R7");

        // R9: unmapped and command pointer bank
        rd_reg(12'h100, "R9");
        rd_reg(addr_of(12'h000, 2), "R9");
        wr_reg(12'h104, 32'hFFFF_FFFF);
        wr_reg(addr_of(12'h000, 6), 32'hFFFF_FFFF);
        rd_reg(12'h380, "R9");

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [NCH-1:0] pv;
            logic [NCH-1:0] pe;
            int op;
            int ch;
            pv = NCH'($urandom & $urandom & $urandom & $urandom);
            pe = NCH'($urandom);
            op = int'($urandom % 8);
            ch = int'($urandom % NCH);
            case (op)
                0, 1, 2: cycle(pv, pe, 1'b0, 1'b1, addr_of(12'h040, ch), 32'h0, "");
                3:       cycle(pv, pe, 1'b1, 1'b0, addr_of(12'h080, ch), $urandom, "");
                4:       cycle(pv, pe, 1'b1, 1'b0, addr_of(12'h300, ch), $urandom, "");
                5:       cycle(pv, pe, 1'b0, 1'b1, addr_of(12'h200, ch), 32'h0, "");
                6:       cycle(pv, pe, 1'b0, 1'b1, 12'h380, 32'h0, "");
                default: cycle(pv, pe, 1'b0, 1'b0, 12'h3FC, 32'h0, "");
            endcase
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule